// File: doc/BRIEF.md
# Rounding and Saturating Result Extractor

This block sits at the output of a multiply-accumulate datapath. It receives a 64-bit operand that is already sign- or zero-extended: either a multiplier product or a 40-bit accumulator widened to 64 bits. It also receives a 4-bit multiply-mode code and a full-word flag. From these it forms a 32-bit result.

In half-word form the operand may first be doubled, then rounded to nearest or truncated by removing its low 16 bits. It is then clamped to a signed or unsigned 16-bit range. In full-word form the operand may be doubled and is then clamped to a signed or unsigned 32-bit range. A saturation flag reports every clamp that changed the value. Mode and form combinations that have no meaning raise an illegal flag and force a zero result.

The datapath is combinational. A parameter adds one output register stage, which is on by default.

Top module: `mac_result_extract`

## Requirements
- R1: Mode codes are: 0 fractional, 1 integer, 2 unsigned fractional, 3 unsigned integer, 4 fractional truncate, 5 unsigned fractional truncate, 6 fractional doubled, 7 integer doubled, 8 integer high. Half-word form accepts all nine codes. Full-word form accepts only 0, 1, 2, 6 and 7. Any other combination gives illegal=1, result=0 and saturated=0.
- R2: Full-word codes 0 and 1 clamp the operand, read as signed 64-bit, to the range 0x80000000..0x7FFFFFFF. In-range values pass through unchanged in bits 31:0.
- R3: Full-word code 2 reads the operand as unsigned. Any value above 0xFFFFFFFF gives 0xFFFFFFFF.
- R4: Full-word codes 6 and 7 shift the operand left by one bit within 64 bits, then clamp it to the signed 32-bit range.
- R5: Rounding adds 0x8000, shifts right by 16, and then sets bits 63:56 of the rounded value back to their value before rounding. Half-word codes 0 and 8 round and then clamp signed to 0x8000..0x7FFF.
- R6: Half-word code 1 clamps the operand signed to 16 bits with no rounding. Half-word code 3 clamps it unsigned to 0xFFFF with no rounding.
- R7: Half-word code 2 rounds as in R5 and then clamps unsigned to 0xFFFF.
- R8: Truncation shifts right by 16 and sets bits 63:56 back to their value before the shift. Half-word code 4 truncates and clamps signed. Code 5 truncates and clamps unsigned.
- R9: Half-word code 6 doubles, rounds and clamps signed. Half-word code 7 doubles and clamps signed, with no rounding.
- R10: A half-word result is placed in bits 15:0, and bits 31:16 are zero.
- R11: saturated is 1 exactly when a clamp replaced the value. A value equal to a range limit does not set it.
- R12: With the output register enabled (the default), outputs follow inputs after one clock edge. A synchronous active-low reset clears result, saturated and illegal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| operand | input | 64 | Sign- or zero-extended product or accumulator value |
| mode | input | 4 | Multiply-mode code, encoded as in R1 |
| fullword | input | 1 | 1 selects the 32-bit result, 0 selects the 16-bit result |
| result | output | 32 | Extracted, clamped result |
| saturated | output | 1 | A clamp changed the value |
| illegal | output | 1 | The mode and form combination is not supported |

## Verification
Rounding and saturation can act on the same value: a rounding carry can push a value that was in range just past the 16-bit limit. The bench provokes this with operands such as 0x7FFF8000 in the rounding modes and expects 0x7FFF with saturated high. The integer-doubled mode is probed the same way, with the doubling itself causing the overflow. The illegal check also overlaps with saturation: operands that would clamp are sent with unsupported combinations, and the bench expects zero with saturated low. A scoreboard compares every vector against a model written separately from the RTL, including a seeded random sweep over all sixteen codes.

// File: rtl/mre_pkg.sv
// Package for the result extractor: mode codes and the control word
// that the mode decoder hands to the datapath.
package mre_pkg;

    typedef enum logic [3:0] {
        MD_FRAC        = 4'd0,
        MD_INT         = 4'd1,
        MD_UFRAC       = 4'd2,
        MD_UINT        = 4'd3,
        MD_FRAC_TRUNC  = 4'd4,
        MD_UFRAC_TRUNC = 4'd5,
        MD_FRAC_X2     = 4'd6,
        MD_INT_X2      = 4'd7,
        MD_INT_HI      = 4'd8
    } mre_mode_e;

    typedef struct packed {
        logic legal;    // combination supported
        logic dbl;      // shift left by one first
        logic rnd;      // round to nearest on bit 16
        logic trn;      // drop low 16 bits
        logic sgn;      // signed clamp
    } mre_ctrl_t;

endpackage

// File: rtl/mre_mode_decode.sv
// Mode decoder: turns the mode code and full-word flag into datapath
// controls. Assumes codes above 8 are unused and flags them illegal.
module mre_mode_decode
    import mre_pkg::*;
#(
    parameter int MODE_W = 4
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              fullword,
    output mre_ctrl_t         ctrl
);

    // Decode table for the full-word and half-word forms.
    always_comb begin
        ctrl = '0;
        if (fullword) begin
            case (mode)
                MD_FRAC, MD_INT:       ctrl = '{legal: 1'b1, dbl: 1'b0, rnd: 1'b0, trn: 1'b0, sgn: 1'b1};
                MD_UFRAC:              ctrl = '{legal: 1'b1, dbl: 1'b0, rnd: 1'b0, trn: 1'b0, sgn: 1'b0};
                MD_FRAC_X2, MD_INT_X2: ctrl = '{legal: 1'b1, dbl: 1'b1, rnd: 1'b0, trn: 1'b0, sgn: 1'b1};
                default:               ctrl = '0;
            endcase
        end else begin
            case (mode)
                MD_FRAC, MD_INT_HI: ctrl = '{legal: 1'b1, dbl: 1'b0, rnd: 1'b1, trn: 1'b0, sgn: 1'b1};
                MD_INT:             ctrl = '{legal: 1'b1, dbl: 1'b0, rnd: 1'b0, trn: 1'b0, sgn: 1'b1};
                MD_UFRAC:           ctrl = '{legal: 1'b1, dbl: 1'b0, rnd: 1'b1, trn: 1'b0, sgn: 1'b0};
                MD_UINT:            ctrl = '{legal: 1'b1, dbl: 1'b0, rnd: 1'b0, trn: 1'b0, sgn: 1'b0};
                MD_FRAC_TRUNC:      ctrl = '{legal: 1'b1, dbl: 1'b0, rnd: 1'b0, trn: 1'b1, sgn: 1'b1};
                MD_UFRAC_TRUNC:     ctrl = '{legal: 1'b1, dbl: 1'b0, rnd: 1'b0, trn: 1'b1, sgn: 1'b0};
                MD_FRAC_X2:         ctrl = '{legal: 1'b1, dbl: 1'b1, rnd: 1'b1, trn: 1'b0, sgn: 1'b1};
                MD_INT_X2:          ctrl = '{legal: 1'b1, dbl: 1'b1, rnd: 1'b0, trn: 1'b0, sgn: 1'b1};
                default:            ctrl = '0;
            endcase
        end
    end

endmodule

// File: rtl/mre_condition.sv
// Operand conditioning: optional doubling, then either rounding or
// truncation of the low RND_SHIFT bits. The top SIGN_KEEP bits of the
// doubled value are restored afterwards so that the sign survives.
module mre_condition #(
    parameter int DATA_W    = 64,
    parameter int RND_SHIFT = 16,
    parameter int SIGN_KEEP = 8
) (
    input  logic [DATA_W-1:0] operand,
    input  logic              dbl,
    input  logic              rnd,
    input  logic              trn,
    output logic [DATA_W-1:0] cond
);

    localparam logic [DATA_W-1:0] KEEP_MASK = {{SIGN_KEEP{1'b1}}, {(DATA_W-SIGN_KEEP){1'b0}}};
    localparam logic [DATA_W-1:0] HALF_LSB  = DATA_W'(1) << (RND_SHIFT - 1);

    logic [DATA_W-1:0] scaled;
    logic [DATA_W-1:0] biased;

    // Scale, bias, shift and restore the sign byte.
    always_comb begin
        scaled = dbl ? {operand[DATA_W-2:0], 1'b0} : operand;
        biased = scaled + (rnd ? HALF_LSB : '0);
        if (rnd || trn)
            cond = (biased >> RND_SHIFT) | (scaled & KEEP_MASK);
        else
            cond = scaled;
    end

endmodule

// File: rtl/mre_clamp.sv
// Range clamp: reduces a wide value to OUT_W bits, signed or unsigned,
// and reports whether the value had to be replaced. Overflow is found
// from the discarded high bits rather than by magnitude comparison.
module mre_clamp #(
    parameter int IN_W  = 64,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  value,
    input  logic             sgn,
    output logic [OUT_W-1:0] clamped,
    output logic             hit
);

    localparam logic [OUT_W-1:0] S_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] S_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    logic ovf_s;
    logic ovf_u;

    // Signed overflow: the sign-extension bits disagree. Unsigned: any high bit set.
    always_comb begin
        ovf_s = !((&value[IN_W-1:OUT_W-1]) || !(|value[IN_W-1:OUT_W-1]));
        ovf_u = |value[IN_W-1:OUT_W];
        if (sgn) begin
            hit     = ovf_s;
            clamped = ovf_s ? (value[IN_W-1] ? S_MIN : S_MAX) : value[OUT_W-1:0];
        end else begin
            hit     = ovf_u;
            clamped = ovf_u ? '1 : value[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/mac_result_extract.sv
// Result extractor top: decodes the mode, conditions the operand, clamps
// it to 32 or 16 bits and selects the form. REG_OUT=1 adds one register
// stage with synchronous active-low reset; REG_OUT=0 is combinational.
module mac_result_extract
    import mre_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int RES_W     = 32,
    parameter int MODE_W    = 4,
    parameter bit REG_OUT   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] operand,
    input  logic [MODE_W-1:0] mode,
    input  logic              fullword,
    output logic [RES_W-1:0]  result,
    output logic              saturated,
    output logic              illegal
);

    localparam int HALF_W = RES_W / 2;

    mre_ctrl_t          ctrl;
    logic [DATA_W-1:0]  cond;
    logic [RES_W-1:0]   full_val;
    logic [HALF_W-1:0]  half_val;
    logic               full_hit;
    logic               half_hit;
    logic [RES_W-1:0]   nxt_result;
    logic               nxt_sat;
    logic               nxt_ill;

    mre_mode_decode #(.MODE_W(MODE_W)) u_dec (
        .mode     (mode),
        .fullword (fullword),
        .ctrl     (ctrl)
    );

    mre_condition #(.DATA_W(DATA_W), .RND_SHIFT(HALF_W), .SIGN_KEEP(8)) u_cond (
        .operand (operand),
        .dbl     (ctrl.dbl),
        .rnd     (ctrl.rnd),
        .trn     (ctrl.trn),
        .cond    (cond)
    );

    mre_clamp #(.IN_W(DATA_W), .OUT_W(RES_W)) u_clamp_full (
        .value   (cond),
        .sgn     (ctrl.sgn),
        .clamped (full_val),
        .hit     (full_hit)
    );

    mre_clamp #(.IN_W(DATA_W), .OUT_W(HALF_W)) u_clamp_half (
        .value   (cond),
        .sgn     (ctrl.sgn),
        .clamped (half_val),
        .hit     (half_hit)
    );

    // Form select, with illegal combinations forced to zero.
    always_comb begin
        nxt_ill = !ctrl.legal;
        if (!ctrl.legal) begin
            nxt_result = '0;
            nxt_sat    = 1'b0;
        end else if (fullword) begin
            nxt_result = full_val;
            nxt_sat    = full_hit;
        end else begin
            nxt_result = {{(RES_W-HALF_W){1'b0}}, half_val};
            nxt_sat    = half_hit;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            // Output register stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    result    <= '0;
                    saturated <= 1'b0;
                    illegal   <= 1'b0;
                end else begin
                    result    <= nxt_result;
                    saturated <= nxt_sat;
                    illegal   <= nxt_ill;
                end
            end
        end else begin : g_comb
            // Direct combinational outputs.
            always_comb begin
                result    = nxt_result;
                saturated = nxt_sat;
                illegal   = nxt_ill;
            end
        end
    endgenerate

endmodule

// File: rtl/mre_checker.sv
// Property checker for the result extractor. Inputs are delayed by the
// output latency so that each property compares outputs with the inputs
// that produced them. Bound into every instance of the top module.
module mre_checker #(
    parameter int DATA_W  = 64,
    parameter int RES_W   = 32,
    parameter int MODE_W  = 4,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] operand,
    input logic [MODE_W-1:0] mode,
    input logic              fullword,
    input logic [RES_W-1:0]  result,
    input logic              saturated,
    input logic              illegal
);

    logic [DATA_W-1:0] a_op;
    logic [MODE_W-1:0] a_mode;
    logic              a_fw;
    logic              armed;

    generate
        if (REG_OUT) begin : g_lat1
            logic [DATA_W-1:0] d_op;
            logic [MODE_W-1:0] d_mode;
            logic              d_fw;
            logic              d_arm;
            // Capture the inputs that the output register is taking.
            always_ff @(posedge clk) begin
                d_op   <= operand;
                d_mode <= mode;
                d_fw   <= fullword;
                d_arm  <= rst_n;
            end
            assign a_op   = d_op;
            assign a_mode = d_mode;
            assign a_fw   = d_fw;
            assign armed  = d_arm;
        end else begin : g_lat0
            assign a_op   = operand;
            assign a_mode = mode;
            assign a_fw   = fullword;
            assign armed  = 1'b1;
        end
    endgenerate

    // R1: unsupported combinations give zero, illegal set, no saturation.
    p_illegal_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ((a_mode > 4'd8) || (a_fw && (a_mode inside {4'd3, 4'd4, 4'd5, 4'd8}))))
        |-> (illegal && result == '0 && !saturated));

    // R2: in-range signed full-word values pass through.
    p_full_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && a_fw && a_mode == 4'd0 && ((&a_op[DATA_W-1:31]) || !(|a_op[DATA_W-1:31])))
        |-> (result == a_op[31:0] && !saturated));

    // R3: unsigned full-word clamp.
    p_full_uclamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && a_fw && a_mode == 4'd2 && (|a_op[DATA_W-1:32]))
        |-> (result == 32'hFFFF_FFFF && saturated));

    // R10: half-word results leave the upper half zero.
    p_half_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !a_fw) |-> (result[RES_W-1:RES_W/2] == '0));

    // R11: a clamp is never reported on an illegal combination.
    p_sat_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        saturated |-> !illegal);

endmodule

bind mac_result_extract mre_checker #(
    .DATA_W  (DATA_W),
    .RES_W   (RES_W),
    .MODE_W  (MODE_W),
    .REG_OUT (REG_OUT)
) u_mre_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .operand   (operand),
    .mode      (mode),
    .fullword  (fullword),
    .result    (result),
    .saturated (saturated),
    .illegal   (illegal)
);

// File: tb/tb_mac_result_extract.sv
`timescale 1ns/1ps
module tb_mac_result_extract;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] operand = '0;
    logic [3:0]  mode = '0;
    logic        fullword = 1'b0;
    logic [31:0] result;
    logic        saturated;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        sat;
        logic        ill;
        int          due;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    mac_result_extract dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .operand   (operand),
        .mode      (mode),
        .fullword  (fullword),
        .result    (result),
        .saturated (saturated),
        .illegal   (illegal)
    );

    // Reference model written from the requirements.
    function automatic void model(input logic [63:0] v, input logic [3:0] m, input logic fw,
                                  output logic [31:0] r, output logic s, output logic il);
        bit ok, dbl, rnd, trn, sgn;
        logic [63:0] x;
        longint sx;
        ok = 0; dbl = 0; rnd = 0; trn = 0; sgn = 0;
        if (fw) begin
            case (m)
                4'd0, 4'd1: begin ok = 1; sgn = 1; end
                4'd2:       begin ok = 1; end
                4'd6, 4'd7: begin ok = 1; sgn = 1; dbl = 1; end
                default: ;
            endcase
        end else begin
            case (m)
                4'd0, 4'd8: begin ok = 1; sgn = 1; rnd = 1; end
                4'd1:       begin ok = 1; sgn = 1; end
                4'd2:       begin ok = 1; rnd = 1; end
                4'd3:       begin ok = 1; end
                4'd4:       begin ok = 1; sgn = 1; trn = 1; end
                4'd5:       begin ok = 1; trn = 1; end
                4'd6:       begin ok = 1; sgn = 1; dbl = 1; rnd = 1; end
                4'd7:       begin ok = 1; sgn = 1; dbl = 1; end
                default: ;
            endcase
        end
        r = '0; s = 1'b0; il = !ok;
        if (!ok) return;
        x = dbl ? (v << 1) : v;
        if (rnd) x = ((x + 64'h8000) >> 16) | (x & 64'hFF00_0000_0000_0000);
        else if (trn) x = (x >> 16) | (x & 64'hFF00_0000_0000_0000);
        sx = longint'(x);
        if (fw) begin
            if (sgn) begin
                if (sx > 64'sh7FFF_FFFF)        begin r = 32'h7FFF_FFFF; s = 1; end
                else if (sx < -64'sh8000_0000)  begin r = 32'h8000_0000; s = 1; end
                else r = x[31:0];
            end else begin
                if (x > 64'hFFFF_FFFF) begin r = 32'hFFFF_FFFF; s = 1; end
                else r = x[31:0];
            end
        end else begin
            if (sgn) begin
                if (sx > 64'sh7FFF)       begin r = 32'h7FFF; s = 1; end
                else if (sx < -64'sh8000) begin r = 32'h8000; s = 1; end
                else r = {16'h0, x[15:0]};
            end else begin
                if (x > 64'hFFFF) begin r = 32'hFFFF; s = 1; end
                else r = {16'h0, x[15:0]};
            end
        end
    endfunction

    // Driver: applies one vector and queues its expected outputs (R12: one cycle later).
    task automatic drive(input logic [63:0] v, input logic [3:0] m, input logic fw, input string tag);
        exp_t e;
        @(negedge clk);
        operand = v; mode = m; fullword = fw;
        model(v, m, fw, e.res, e.sat, e.ill);
        e.due = cyc + 1;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: pops matured items and compares them with the outputs.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (result !== e.res || saturated !== e.sat || illegal !== e.ill) begin
                errors++;
                $display("FAIL %s: got res=%h sat=%b ill=%b, expected res=%h sat=%b ill=%b",
                         e.tag, result, saturated, illegal, e.res, e.sat, e.ill);
            end
        end
    end

    task automatic check_reset(input string tag);
        checks++;
        if (result !== 32'h0 || saturated !== 1'b0 || illegal !== 1'b0) begin
            errors++;
            $display("FAIL %s: got res=%h sat=%b ill=%b, expected res=0 sat=0 ill=0",
                     tag, result, saturated, illegal);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] lf;
        lf = 64'h9E37_79B9_7F4A_7C15;
        operand = 64'h7FFF_8000; mode = 4'd0; fullword = 1'b0;
        repeat (3) @(negedge clk);
        check_reset("R12 reset clears outputs");
        @(negedge clk); rst_n = 1'b1;

        // R2 full-word signed
        drive(64'h0000_0000_7FFF_FFFF, 4'd0, 1, "R2 at max");
        drive(64'h0000_0000_8000_0000, 4'd0, 1, "R2 above max");
        drive(64'hFFFF_FFFF_8000_0000, 4'd0, 1, "R2 at min");
        drive(64'hFFFF_FFFF_7FFF_FFFF, 4'd1, 1, "R2 below min");
        drive(64'h0000_0000_0000_1234, 4'd1, 1, "R2 small");
        // R3 full-word unsigned
        drive(64'h0000_0001_0000_0000, 4'd2, 1, "R3 above");
        drive(64'h0000_0000_FFFF_FFFF, 4'd2, 1, "R3 at max");
        // R4 full-word doubled
        drive(64'h0000_0000_4000_0000, 4'd6, 1, "R4 doubled overflow");
        drive(64'h0000_0000_3FFF_FFFF, 4'd6, 1, "R4 doubled fits");
        drive(64'hFFFF_FFFF_C000_0000, 4'd7, 1, "R4 doubled negative");
        // R5 half rounding signed
        drive(64'h0000_0000_0000_7FFF, 4'd0, 0, "R5 round down");
        drive(64'h0000_0000_0000_8000, 4'd0, 0, "R5 round up");
        drive(64'h0000_0000_7FFF_7FFF, 4'd8, 0, "R5 at max");
        drive(64'h0000_0000_7FFF_8000, 4'd0, 0, "R5 round then clamp");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 4'd8, 0, "R5 sign byte kept");
        // R6 half integer
        drive(64'h0000_0000_0000_7FFF, 4'd1, 0, "R6 signed at max");
        drive(64'h0000_0000_0000_8000, 4'd1, 0, "R6 signed over");
        drive(64'hFFFF_FFFF_FFFF_8000, 4'd1, 0, "R6 signed at min");
        drive(64'h0000_0000_0001_0000, 4'd3, 0, "R6 unsigned over");
        // R7 half unsigned rounding
        drive(64'h0000_0000_FFFF_8000, 4'd2, 0, "R7 round then clamp");
        drive(64'h0000_0000_1234_8000, 4'd2, 0, "R7 round up");
        // R8 truncation
        drive(64'h0000_0000_1234_FFFF, 4'd4, 0, "R8 signed truncate");
        drive(64'h0000_FFFF_FFFF_FFFF, 4'd5, 0, "R8 unsigned truncate clamp");
        // R9 half doubled
        drive(64'h0000_0000_3FFF_8000, 4'd6, 0, "R9 doubled round");
        drive(64'h0000_0000_0000_4000, 4'd7, 0, "R9 doubled clamp");
        // R1 illegal
        drive(64'h0000_0000_8000_0000, 4'd9,  0, "R1 code 9");
        drive(64'h0000_0001_0000_0000, 4'd15, 1, "R1 code 15");
        drive(64'h0000_0000_7FFF_8000, 4'd3,  1, "R1 full code 3");
        drive(64'h0000_0000_7FFF_8000, 4'd8,  1, "R1 full code 8");
        drive(64'h0000_00FF_FFFF_FFFF, 4'd5,  1, "R1 full code 5");
        // R10 and R11: random sweep over codes, forms and operand shapes
        for (int i = 0; i < 600; i++) begin
            logic [63:0] v;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 7); lf = lf ^ (lf << 17);
            case (lf[1:0])
                2'd0: v = {{32{lf[40]}}, lf[40:9]};
                2'd1: v = {{24{lf[50]}}, lf[50:11]};
                2'd2: v = {32'h0, lf[47:16]};
                default: v = lf;
            endcase
            drive(v, lf[61:58], lf[62], "R10 R11 sweep");
        end
        repeat (3) @(negedge clk);
        // R12: synchronous reset with hostile inputs
        operand = 64'h0000_0001_0000_0000; mode = 4'd2; fullword = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check_reset("R12 reset after run");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule